// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block fades a stereo sample stream in and out without audible clicks. Every output sample period a strobe presents one left and one right sample. The block multiplies both samples by a shared gain and registers the results. The gain moves one step per strobe. While the mute request is high it walks down toward silence. While the request is low it walks back up toward unity. A full fade in either direction spans 1024 sample periods.

If the mute request changes while a fade is still running, the gain turns around at the level it has reached. It then moves the other way at the same per-sample rate. The gain is held in a 10-bit code. The top code means exact unity, so an unmuted stream passes through bit-exact. Code zero forces silence.

Top module: `smr_soft_mute`

## Requirements
- R1: After reset both outputs are zero, `out_stb` is low and the gain code is at its top value (1023), so the first sample after reset passes unchanged.
- R2: A sample presented with `smp_stb` high at a clock edge appears on the outputs after that edge, and `out_stb` is high for exactly that one cycle.
- R3: At each strobe with `mute_req` high, the gain code drops by one and stops at 0. Starting from unity, the 1024th muted sample is exactly zero.
- R4: At each strobe with `mute_req` low, the gain code rises by one and stops at 1023. Starting from full mute, the 1024th released sample is at unity.
- R5: A change of `mute_req` partway through a fade reverses the direction at the next strobe, starting from the current code and at the same rate of one code per strobe.
- R6: While the gain code is 0, both outputs are exactly zero for any input, including the most negative value.
- R7: Without a strobe, the gain code and both outputs hold their values, and toggling `mute_req` has no effect.
- R8: Each output equals the input times the multiplier, shifted right arithmetically by 10 (rounding toward minus infinity). The multiplier equals the gain code, except that code 1023 uses 1024, so at unity even the extreme values come out exactly.
- R9: The left and right channels are scaled independently of each other, by the same gain code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One sample period: samples valid, gain steps |
| mute_req | input | 1 | High fades toward silence, low fades toward unity |
| in_left | input | DATA_W | Signed left sample |
| in_right | input | DATA_W | Signed right sample |
| out_left | output | DATA_W | Scaled signed left sample |
| out_right | output | DATA_W | Scaled signed right sample |
| out_stb | output | 1 | Scaled samples updated this cycle |

## Verification
The assertions assume that `mute_req` and the samples are sampled only at a strobe edge, and that samples are full-range two's complement values of DATA_W bits. They do not assume any particular strobe spacing: back-to-back strobes and gaps are both legal. The stimulus changes every input half a cycle away from the active edge. It uses both continuous and gapped strobes, and toggles `mute_req` between strobes to probe the hold behaviour. It uses sample values up to the positive and negative limits, so that the exact-unity and forced-zero ends are both reached.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_UP   = 2'd2
   } step_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp
   import smr_pkg::*;
#(
   parameter int STEPS = 1024
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      stb,
   input  logic                      mute,
   output logic [$clog2(STEPS):0]    gain_mult,
   output logic                      zero_gain
);
   localparam int GW = $clog2(STEPS);
   localparam logic [GW-1:0] TOP_CODE = GW'(STEPS - 1);
   localparam logic [GW:0]   UNITY    = (GW+1)'(STEPS);

   generate
      if (!is_pow2(STEPS) || STEPS < 4) begin : g_bad_steps
         $error("smr_gain_ramp: STEPS must be a power of two of at least 4");
      end
   endgenerate

   logic [GW-1:0] code;
   step_e         step;

   always_comb begin
      step = STEP_HOLD;
      if (stb) begin
         if (mute) begin
            if (code != '0) step = STEP_DOWN;
         end else begin
            if (code != TOP_CODE) step = STEP_UP;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= TOP_CODE;
      end else begin
         unique case (step)
            STEP_DOWN: code <= code - 1'b1;
            STEP_UP:   code <= code + 1'b1;
            default:   code <= code;
         endcase
      end
   end

   assign gain_mult = (code == TOP_CODE) ? UNITY : {1'b0, code};
   assign zero_gain = (code == '0);

   assert_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && mute && code != '0) |=> code == GW'($past(code) - 1'b1));
   assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && mute && code == '0) |=> code == '0);
   assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !mute && code != TOP_CODE) |=> code == GW'($past(code) + 1'b1));
   assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !mute && code == TOP_CODE) |=> code == TOP_CODE);
   assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(code));
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
   parameter int DATA_W     = 24,
   parameter int GW         = 10,
   parameter bit FORCE_ZERO = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb,
   input  logic [GW:0]              gain_mult,
   input  logic                     zero_gain,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] dout
);
   localparam int PW = DATA_W + GW;

   generate
      if (DATA_W < 2 || GW < 2) begin : g_bad_width
         $error("smr_scaler: DATA_W and GW must each be at least 2");
      end
   endgenerate

   logic signed [PW-1:0]     din_ext;
   logic signed [PW-1:0]     mult_ext;
   logic signed [PW-1:0]     prod;
   logic signed [DATA_W-1:0] scaled;
   logic signed [DATA_W-1:0] chosen;

   assign din_ext  = PW'(din);
   assign mult_ext = $signed(PW'(gain_mult));
   assign prod     = din_ext * mult_ext;
   assign scaled   = DATA_W'(prod >>> GW);

   generate
      if (FORCE_ZERO) begin : g_force_zero
         assign chosen = zero_gain ? '0 : scaled;
      end else begin : g_plain
         assign chosen = scaled;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dout <= '0;
      else if (stb) dout <= chosen;
   end

   assert_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && zero_gain) |=> dout == '0);
   assert_unity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && gain_mult == (GW+1)'(1 << GW)) |=> dout == $past(din));
   assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(dout));
endmodule

// File: rtl/smr_soft_mute.sv
module smr_soft_mute #(
   parameter int DATA_W = 24,
   parameter int STEPS  = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic                     mute_req,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   output logic signed [DATA_W-1:0] out_left,
   output logic signed [DATA_W-1:0] out_right,
   output logic                     out_stb
);
   localparam int GW  = $clog2(STEPS);
   localparam int NCH = 2;

   logic [GW:0]              gain_mult;
   logic                     zero_gain;
   logic signed [DATA_W-1:0] ch_in  [NCH];
   logic signed [DATA_W-1:0] ch_out [NCH];

   smr_gain_ramp #(.STEPS(STEPS)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (smp_stb),
      .mute      (mute_req),
      .gain_mult (gain_mult),
      .zero_gain (zero_gain)
   );

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         smr_scaler #(.DATA_W(DATA_W), .GW(GW), .FORCE_ZERO(1'b1)) u_scale (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (smp_stb),
            .gain_mult (gain_mult),
            .zero_gain (zero_gain),
            .din       (ch_in[c]),
            .dout      (ch_out[c])
         );
      end
   endgenerate

   assign out_left  = ch_out[0];
   assign out_right = ch_out[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_stb <= 1'b0;
      else        out_stb <= smp_stb;
   end

   assert_stb_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> out_stb);
   assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !out_stb);
endmodule

// File: tb/tb_smr_soft_mute.sv
`timescale 1ns/1ps
module tb_smr_soft_mute;
   localparam int DATA_W = 24;
   localparam int STEPS  = 1024;
   localparam int SH     = 10;
   localparam int MAXV   = (1 << (DATA_W-1)) - 1;
   localparam int MINV   = -(1 << (DATA_W-1));

   typedef struct {
      longint l;
      longint r;
      string  tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic mute_req = 1'b0;
   logic signed [DATA_W-1:0] in_left = '0;
   logic signed [DATA_W-1:0] in_right = '0;
   logic signed [DATA_W-1:0] out_left;
   logic signed [DATA_W-1:0] out_right;
   logic out_stb;

   int total = 0;
   int bad = 0;
   int model_code = STEPS - 1;
   int cycles = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   smr_soft_mute #(.DATA_W(DATA_W), .STEPS(STEPS)) dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mute_req(mute_req),
      .in_left(in_left), .in_right(in_right),
      .out_left(out_left), .out_right(out_right), .out_stb(out_stb)
   );

   function automatic longint scale(input int v, input int code);
      longint m;
      m = (code == STEPS - 1) ? longint'(STEPS) : longint'(code);
      return (longint'(v) * m) >>> SH;
   endfunction

   task automatic check(input string tag, input longint got, input longint exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   // driver: called at a falling edge, returns at a falling edge
   task automatic send(input int l, input int r, input bit m, input string tag, input int gap);
      exp_t e;
      in_left  = l[DATA_W-1:0];
      in_right = r[DATA_W-1:0];
      mute_req = m;
      smp_stb  = 1'b1;
      e.l = scale(l, model_code);
      e.r = scale(r, model_code);
      e.tag = tag;
      q.push_back(e);
      if (m && model_code > 0) model_code--;
      else if (!m && model_code < STEPS - 1) model_code++;
      @(negedge clk);
      smp_stb = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_stb) begin
         if (q.size() == 0) begin
            check("R2 unexpected out_stb", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " left"},  longint'(out_left),  e.l);
            check({e.tag, " right"}, longint'(out_right), e.r);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog got=%0d exp=<150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic drain();
      repeat (3) @(negedge clk);
      check("R2 queue drained", q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_left at reset", longint'(out_left), 0);
      check("R1 out_right at reset", longint'(out_right), 0);
      check("R1 out_stb at reset", out_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      send(12345, -6789, 1'b0, "R1 unity after reset", 1);

      // R8: exact unity at extremes; R2 strobe timing with gap
      send(MAXV, MINV, 1'b0, "R8 extremes", 0);
      send(MINV, MAXV, 1'b0, "R8 extremes swapped", 0);
      send(-1, 1, 1'b0, "R8 small", 2);
      check("R2 out_stb low between strobes", out_stb, 0);

      // R3 + R9: full fade down, different per-channel inputs
      for (int i = 0; i < STEPS; i++)
         send(MAXV - i * 37, MINV + i * 53, 1'b1, "R3 fade down", 0);
      // R6: code 0 gives zero for any input
      send(MINV, MAXV, 1'b1, "R6 floor extremes", 0);
      send(-1, 777, 1'b1, "R6 floor small", 1);
      check("R6 floor model code", model_code, 0);

      // R7: no strobe, mute toggling has no effect
      begin
         longint hl, hr;
         hl = longint'(out_left);
         hr = longint'(out_right);
         for (int k = 0; k < 12; k++) begin
            mute_req = ~mute_req;
            in_left  = DATA_W'(k * 1000);
            @(negedge clk);
            check("R7 hold left", longint'(out_left), hl);
            check("R7 hold right", longint'(out_right), hr);
         end
      end

      // R4: fade up, with gapped strobes at the start
      for (int i = 0; i < STEPS; i++)
         send(4000000 - i * 11, -3000000 + i * 7, 1'b0, "R4 fade up", (i < 8) ? 2 : 0);
      send(MAXV, MINV, 1'b0, "R4 ceiling unity", 0);

      // R5: reversal mid fade
      for (int i = 0; i < 300; i++)
         send(2000000, -2000000 + i, 1'b1, "R5 partial down", 0);
      for (int i = 0; i < 100; i++)
         send(-1500000, 1500000, 1'b0, "R5 reversed up", 0);
      for (int i = 0; i < 50; i++)
         send(999999, -999999, 1'b1, "R5 reversed down", 0);
      for (int i = 0; i < 260; i++)
         send(-7, 8388000, 1'b0, "R5 climb back", 0);
      send(MAXV, MINV, 1'b0, "R5 back at unity", 0);
      drain();

      // R1: reset mid-fade returns to unity
      for (int i = 0; i < 100; i++)
         send(3000000, -3000000, 1'b1, "R3 pre-reset fade", 0);
      drain();
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 left cleared by reset", longint'(out_left), 0);
      check("R1 right cleared by reset", longint'(out_right), 0);
      model_code = STEPS - 1;
      rst_n = 1'b1;
      @(negedge clk);
      send(3000000, -3000000, 1'b0, "R1 unity after mid reset", 0);
      drain();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule